// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Shared Auto-Increment Pointer

This block lets a host reach a bank of byte-wide registers over a two-wire serial bus (I2C). It samples the clock and data lines with the system clock, finds start and stop conditions, and reacts to one fixed address pair: 24h selects a write transfer and 25h a read transfer. A write transfer first loads a byte pointer and then stores each further byte at that pointer. A read transfer sends bytes starting at the current pointer. One pointer serves both directions and steps by one after every byte.

The low part of the address space is control storage: entries 00h to 1Eh can be written and read, and every entry drives a slice of a flat output bus. The next six entries, 1Fh to 24h, are read-only and reflect a status input bus. Addresses above 24h read as zero. The slave pulls the data line low through an open-drain enable and never drives it high. It does not stretch the clock.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset every control register is 00h, the pointer is 00h and `sda_oe` is 0.
- R2: The slave pulls SDA low in the acknowledge slot only after an address byte of 24h or 25h (bits sent MSB first). For any other address byte it does not acknowledge and ignores the rest of the transfer, and `sda_oe` stays 0 while no transfer is addressed to it.
- R3: In a write transfer the byte after 24h loads the pointer. Each later byte, assembled MSB first, is stored at the pointer and then acknowledged, and the pointer steps by one. There is no limit on the number of bytes. Control register k appears on `ctrl_o[8k+7:8k]`.
- R4: In a read transfer (address 25h) the slave sends the byte at the pointer MSB first, changing SDA only while SCL is low, and the pointer then steps by one. A master acknowledge (SDA low) asks for the next byte. A not-acknowledge ends the read.
- R5: Addresses 1Fh to 24h read `stat_i[8j+7:8j]` with j = address - 1Fh. Writes to them are acknowledged and change nothing.
- R6: The pointer wraps from FFh to 00h. Addresses 25h to FFh read 00h, and writes to them are acknowledged and change nothing.
- R7: A stop or start condition before the eighth bit of a byte drops that byte: no register changes and the pointer does not move.
- R8: The pointer persists across transfers. A read with no preceding pointer load continues where the last write or read left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the data line is pulled low (open drain) |
| stat_i | input | NUM_STAT*8 | Status bytes shown at addresses 1Fh and above |
| ctrl_o | output | NUM_CTRL*8 | Contents of the control registers, register 0 in the lowest byte |

## Verification
The bench aims at the pointer edges. A burst that crosses from FEh through the wrap shows whether the counter carries into a wrong value or stalls. Bursts that straddle the 1Eh/1Fh boundary show whether a status address gets written or a control address gets refused. Transfers broken off after three or five bits, by a stop or by a repeated start, catch a design that commits a partial byte or moves the pointer early. Foreign addresses such as 26h and 48h, and reads that resume without a pointer load, expose a decoder that acknowledges too much and a pointer that is cleared or left stale between transfers.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e            st;
        bus_st_e            after;
        logic [2:0]         cnt;
        logic               done;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  ptr;
        logic               oe;
        logic               macked;
    } bus_ctx_t;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
            prev_q <= '1;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign q      = stage_q[STAGES-1];
    assign q_prev = prev_q;
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank import i2c_rf_pkg::*; #(
    parameter int NUM_CTRL = 31,
    parameter int NUM_STAT = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          rd_addr,
    input  logic [NUM_STAT*BYTE_W-1:0] stat_i,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0]          rd_data
);
    logic [BYTE_W-1:0] regs_q [NUM_CTRL];
    logic [BYTE_W-1:0] regs_d [NUM_CTRL];

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && wr_addr == BYTE_W'(g)) regs_d[g] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end

        assign ctrl_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CTRL; c++)
            if (rd_addr == BYTE_W'(c)) rd_data = regs_q[c];
        for (int s = 0; s < NUM_STAT; s++)
            if (rd_addr == BYTE_W'(NUM_CTRL + s)) rd_data = stat_i[s*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave import i2c_rf_pkg::*; #(
    parameter logic [6:0] DEV_ADDR    = 7'h12,
    parameter int         NUM_CTRL    = 31,
    parameter int         NUM_STAT    = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [NUM_STAT*BYTE_W-1:0] stat_i,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o
);
    localparam logic [BYTE_W-1:0] WR_CODE = {DEV_ADDR, 1'b0};
    localparam logic [BYTE_W-1:0] RD_CODE = {DEV_ADDR, 1'b1};

    logic [1:0] lvl, prv;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    bus_ctx_t          cur_q, nx_d;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] ptr_w;
    logic              idle_w;

    i2c_rf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({scl_i, sda_i}),
        .q      (lvl),
        .q_prev (prv)
    );

    assign scl_s    = lvl[1];
    assign sda_s    = lvl[0];
    assign scl_rise = scl_s & ~prv[1];
    assign scl_fall = ~scl_s & prv[1];
    assign start_c  = scl_s & prv[1] & prv[0] & ~sda_s;
    assign stop_c   = scl_s & prv[1] & ~prv[0] & sda_s;
    assign rx_byte  = {cur_q.sh[BYTE_W-2:0], sda_s};

    i2c_rf_regbank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cur_q.ptr),
        .wr_data (wr_data),
        .rd_addr (cur_q.ptr),
        .stat_i  (stat_i),
        .ctrl_o  (ctrl_o),
        .rd_data (rd_data)
    );

    always_comb begin
        nx_d    = cur_q;
        wr_en   = 1'b0;
        wr_data = rx_byte;
        if (start_c) begin
            nx_d.st   = ST_DEV;
            nx_d.cnt  = '0;
            nx_d.done = 1'b0;
            nx_d.oe   = 1'b0;
        end else if (stop_c) begin
            nx_d.st   = ST_IDLE;
            nx_d.done = 1'b0;
            nx_d.oe   = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_DEV, ST_PTR, ST_WDATA: begin
                    if (scl_rise && !cur_q.done) begin
                        nx_d.sh  = rx_byte;
                        nx_d.cnt = cur_q.cnt + 3'd1;
                        if (cur_q.cnt == 3'd7) begin
                            nx_d.done = 1'b1;
                            if (cur_q.st == ST_WDATA) begin
                                wr_en    = 1'b1;
                                nx_d.ptr = cur_q.ptr + 8'd1;
                            end else if (cur_q.st == ST_PTR) begin
                                nx_d.ptr = rx_byte;
                            end
                        end
                    end else if (scl_fall && cur_q.done) begin
                        nx_d.done = 1'b0;
                        nx_d.cnt  = '0;
                        if (cur_q.st == ST_DEV) begin
                            if (cur_q.sh == WR_CODE) begin
                                nx_d.oe    = 1'b1;
                                nx_d.st    = ST_SACK;
                                nx_d.after = ST_PTR;
                            end else if (cur_q.sh == RD_CODE) begin
                                nx_d.oe    = 1'b1;
                                nx_d.st    = ST_SACK;
                                nx_d.after = ST_RDATA;
                            end else begin
                                nx_d.st = ST_IDLE;
                            end
                        end else begin
                            nx_d.oe    = 1'b1;
                            nx_d.st    = ST_SACK;
                            nx_d.after = ST_WDATA;
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        nx_d.cnt = '0;
                        nx_d.st  = cur_q.after;
                        if (cur_q.after == ST_RDATA) begin
                            nx_d.sh = rd_data;
                            nx_d.oe = ~rd_data[BYTE_W-1];
                        end else begin
                            nx_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cur_q.cnt == 3'd7) begin
                            nx_d.oe     = 1'b0;
                            nx_d.ptr    = cur_q.ptr + 8'd1;
                            nx_d.st     = ST_MACK;
                            nx_d.macked = 1'b0;
                        end else begin
                            nx_d.cnt = cur_q.cnt + 3'd1;
                            nx_d.sh  = {cur_q.sh[BYTE_W-2:0], 1'b0};
                            nx_d.oe  = ~cur_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        nx_d.macked = ~sda_s;
                    end else if (scl_fall) begin
                        if (cur_q.macked) begin
                            nx_d.sh  = rd_data;
                            nx_d.oe  = ~rd_data[BYTE_W-1];
                            nx_d.cnt = '0;
                            nx_d.st  = ST_RDATA;
                        end else begin
                            nx_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, after: ST_IDLE, cnt: '0, done: 1'b0,
                       sh: '0, ptr: '0, oe: 1'b0, macked: 1'b0};
        end else begin
            cur_q <= nx_d;
        end
    end

    assign sda_oe = cur_q.oe;
    assign ptr_w  = cur_q.ptr;
    assign idle_w = (cur_q.st == ST_IDLE);
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
    parameter int CTRL_BITS = 248,
    parameter int PTR_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_oe,
    input logic [CTRL_BITS-1:0] ctrl_o,
    input logic [PTR_W-1:0]     ptr,
    input logic                 idle
);
    // R1
    ctrl_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_o == '0 && ptr == '0 && !sda_oe));

    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe);

    // R4
    sda_moves_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R3
    store_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> scl_i);

    // R8
    ptr_moves_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> !$past(idle));
endmodule

bind i2c_regfile_slave i2c_rf_chk #(.CTRL_BITS(NUM_CTRL*8), .PTR_W(8)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .ctrl_o (ctrl_o),
    .ptr    (ptr_w),
    .idle   (idle_w)
);

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;
    localparam int NC = 31;
    localparam int NS = 6;
    localparam int QT = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [NS*8-1:0] stat_i;
    logic [NC*8-1:0] ctrl_o;

    logic [7:0] mreg [NC];
    logic [7:0] mstat [NS];
    logic [7:0] mptr;
    int checks = 0;
    int errors = 0;
    logic ack;
    logic [7:0] rb;
    int unused_seed;

    always #5 clk = ~clk;
    assign sda_line = !(m_low || sda_oe);
    always_comb for (int s = 0; s < NS; s++) stat_i[s*8 +: 8] = mstat[s];

    i2c_regfile_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .stat_i(stat_i), .ctrl_o(ctrl_o)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a < 8'(NC)) return mreg[a];
        if (a < 8'(NC + NS)) return mstat[a - 8'(NC)];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_ctrl(input string req);
        for (int k = 0; k < NC; k++) check(req, 32'(ctrl_o[k*8 +: 8]), 32'(mreg[k]));
    endtask

    task automatic bit_out(input logic b);
        m_low = ~b; #(QT); scl = 1'b1; #(2*QT); scl = 1'b0; #(QT);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; #(QT); scl = 1'b1; #(QT); b = sda_line; #(QT); scl = 1'b0; #(QT);
    endtask

    task automatic bus_start();
        m_low = 1'b0; #(QT); scl = 1'b1; #(QT); m_low = 1'b1; #(QT); scl = 1'b0; #(QT);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; #(QT); scl = 1'b1; #(QT); m_low = 1'b0; #(2*QT);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        logic s;
        send_bits(b, 8);
        bit_in(s);
        a = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_in(s); b[i] = s; end
        bit_out(~give_ack);
    endtask

    task automatic wr_burst(input logic [7:0] p, input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h24, a); check("R2 write address ack", 32'(a), 1);
        send_byte(p, a);     check("R3 pointer ack", 32'(a), 1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a); check("R3 data ack", 32'(a), 1);
            if (mptr < 8'(NC)) mreg[mptr] = d;
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(8'h24, a); check("R2 write address ack", 32'(a), 1);
        send_byte(p, a);     check("R3 pointer ack", 32'(a), 1);
        mptr = p;
        bus_stop();
    endtask

    task automatic rd_cur(input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h25, a); check("R2 read address ack", 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(req, 32'(b), 32'(exp_read(mptr)));
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        unused_seed = $urandom(32'd20240611);
        for (int k = 0; k < NC; k++) mreg[k] = 8'h00;
        for (int s = 0; s < NS; s++) mstat[s] = 8'($urandom);
        mptr = 8'h00;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sda_oe", 32'(sda_oe), 0);
        check_ctrl("R1 control reset");
        rd_cur(2, "R1 reset read");

        // R3 R4 directed write then read back
        wr_burst(8'h02, 4);
        check_ctrl("R3 control bus");
        set_ptr(8'h02);
        rd_cur(4, "R4 readback");

        // R2 foreign addresses
        bus_start();
        send_byte(8'h26, ack); check("R2 no ack 26h", 32'(ack), 0);
        send_byte(8'h00, ack); check("R2 ignored byte", 32'(ack), 0);
        send_byte(8'h5A, ack);
        bus_stop();
        bus_start();
        send_byte(8'h48, ack); check("R2 no ack 48h", 32'(ack), 0);
        bus_stop();
        check_ctrl("R2 nothing written");
        rd_cur(1, "R8 pointer kept after foreign address");

        // R5 read-only range
        wr_burst(8'h1D, 9);
        check_ctrl("R5 status writes ignored");
        set_ptr(8'h1D);
        rd_cur(8, "R5 control/status boundary read");

        // R6 wrap and high addresses
        wr_burst(8'hFE, 3);
        check("R6 wrap wrote 00h", 32'(ctrl_o[7:0]), 32'(mreg[0]));
        rd_cur(1, "R6 after wrap");
        set_ptr(8'h23);
        rd_cur(5, "R6 above status reads zero");
        set_ptr(8'hFF);
        rd_cur(2, "R6 read wrap");

        // R7 abort by stop
        set_ptr(8'h05);
        bus_start();
        send_byte(8'h24, ack); send_byte(8'h05, ack);
        send_byte(8'hA5, ack); mreg[5] = 8'hA5; mptr = 8'h06;
        send_bits(8'h3C, 5);
        bus_stop();
        check("R7 stop abort", 32'(ctrl_o[6*8 +: 8]), 32'(mreg[6]));
        check("R3 full byte kept", 32'(ctrl_o[5*8 +: 8]), 32'hA5);
        rd_cur(1, "R7 pointer not moved");

        // R7 abort by repeated start
        bus_start();
        send_byte(8'h24, ack); send_byte(8'h0A, ack);
        send_bits(8'hC3, 3);
        bus_start();
        send_byte(8'h24, ack); check("R7 restart ack", 32'(ack), 1);
        send_byte(8'h0B, ack);
        send_byte(8'h77, ack); mreg[11] = 8'h77; mptr = 8'h0C;
        bus_stop();
        check_ctrl("R7 restart abort");

        // R8 random bursts, read continues on shared pointer
        for (int it = 0; it < 10; it++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(0, NC + NS - 1));
            n = $urandom_range(1, 5);
            for (int s = 0; s < NS; s++) mstat[s] = 8'($urandom);
            wr_burst(p, n);
            rd_cur(2, "R8 continue after write");
            set_ptr(p);
            rd_cur(n + 1, "R4 random readback");
            check_ctrl("R3 random control bus");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule